// File: doc/BRIEF.md
# Run-time Programmable Delay Line

This block delays a data word by a number of clock cycles that can be chosen while it runs. Every clock, each word entering the block moves one step further along a fixed chain of registers. A delay select input picks which point of that chain drives the output. A select of zero skips the chain altogether, so the input reaches the output through a multiplexer only.

The chain moves forward on every clock, whatever the select value is. Changing the select therefore gives the new delay in the same cycle, because the history it needs is already held in the chain. A synchronous reset clears every stage, so any delay longer than the history gathered since reset shows zeros. The data path has no valid/ready handshake. The line advances on every clock and cannot be paused, so no back-pressure applies to it. The select is a plain control pin.

The data width and the deepest delay are parameters; the select width follows from the deepest delay. When the select can encode more values than the chain has stages, the values above the deepest delay are held at the deepest delay.

Top module: `prog_delay_line`

## Requirements
- R1: While reset is asserted at a rising edge, every stage is cleared to zero. Afterwards, with any select k greater than zero, the output is zero until k words have been captured since reset.
- R2: A select of 0 drives the output with the current input word in the same cycle, with no register in the path.
- R3: A select of k, where 1 <= k <= MAX_DELAY, drives the output with the word that was captured k rising edges earlier. Capture at the latest edge counts as one.
- R4: The chain advances on every rising edge whatever the select. A new select value takes effect in the same cycle and uses the history already stored.
- R5: The deepest delay, MAX_DELAY, defaults to 63, which gives a 6-bit select. The full range 0..63 is usable.
- R6: Data width is the parameter WIDTH, defaulting to 1. Every bit of a multi-bit word is delayed together.
- R7: When the select width can encode values above MAX_DELAY, any such value gives the MAX_DELAY delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the chain advances on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all stages |
| din | input | WIDTH | Data word entering the line |
| dly_sel | input | SEL_W | Number of cycles of delay; 0 is a direct pass |
| dout | output | WIDTH | Data word taken from the selected point |

## Verification
A stage stuck at a value, or one that fails to shift, shows at the output as soon as the select points at or beyond that stage. This happens no later than the select value in cycles after the fault. A select decode that is off by one gives the neighbouring word in the same cycle. It is caught on the first cycle in which consecutive input words differ. Faults in reset clearing show in the first cycles after reset, while the selected stage still holds data from before the reset.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  // Bits needed to encode delays 0..max_delay.
  function automatic int sel_bits(input int max_delay);
    if (max_delay < 1) return 1;
    return $clog2(max_delay + 1);
  endfunction
endpackage

// File: rtl/pdl_stage_chain.sv
module pdl_stage_chain #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 63
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WIDTH-1:0]            din,
  output logic [DEPTH:0][WIDTH-1:0]   taps
);
  logic [DEPTH:1][WIDTH-1:0] stage_q;

  // Tap 0 is the undelayed input.
  assign taps[0] = din;

  for (genvar g = 1; g <= DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= '0;
      else     stage_q[g] <= taps[g-1];
    end
    assign taps[g] = stage_q[g];
  end
endmodule

// File: rtl/pdl_tap_select.sv
module pdl_tap_select #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 63,
  parameter int SEL_W = pdl_pkg::sel_bits(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DEPTH:0][WIDTH-1:0]   taps,
  input  logic [SEL_W-1:0]            sel,
  output logic [WIDTH-1:0]            dout
);
  localparam int SEL_SPAN = (1 << SEL_W) - 1;
  logic [SEL_W-1:0] pick;

  if (SEL_SPAN > DEPTH) begin : g_sat
    always_comb pick = (sel > SEL_W'(DEPTH)) ? SEL_W'(DEPTH) : sel;

    // Out-of-range selects read the deepest stage.
    p_clamp_r7: assert property (@(posedge clk) disable iff (rst)
      (sel > SEL_W'(DEPTH)) |-> (dout == taps[DEPTH]));
  end else begin : g_full
    always_comb pick = sel;
  end

  assign dout = taps[pick];
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int WIDTH     = 1,
  parameter int MAX_DELAY = 63,
  parameter int SEL_W     = pdl_pkg::sel_bits(MAX_DELAY)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic [SEL_W-1:0] dly_sel,
  output logic [WIDTH-1:0] dout
);
  logic [MAX_DELAY:0][WIDTH-1:0] taps;

  pdl_stage_chain #(.WIDTH(WIDTH), .DEPTH(MAX_DELAY)) u_chain (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .taps (taps)
  );

  pdl_tap_select #(.WIDTH(WIDTH), .DEPTH(MAX_DELAY), .SEL_W(SEL_W)) u_sel (
    .clk  (clk),
    .rst  (rst),
    .taps (taps),
    .sel  (dly_sel),
    .dout (dout)
  );

  // Set once a non-reset edge has passed; gates history-based checks.
  logic warm_q;
  always_ff @(posedge clk) begin
    if (rst) warm_q <= 1'b0;
    else     warm_q <= 1'b1;
  end

  p_zero_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (dly_sel == '0) |-> (dout == din));

  p_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    (warm_q && dly_sel == SEL_W'(1)) |-> (dout == $past(din)));

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && dly_sel != '0) |-> (dout == '0));

  // One step deeper after one shift returns the same word (R4).
  p_step_deeper_r4: assert property (@(posedge clk) disable iff (rst)
    (warm_q && $past(dly_sel) != '0 && dly_sel != '0 &&
     dly_sel <= SEL_W'(MAX_DELAY) &&
     (dly_sel - $past(dly_sel)) == SEL_W'(1))
    |-> (dout == $past(dout)));
endmodule

// File: tb/sim_prog_delay_line.sv
module sim_prog_delay_line;
  localparam int M0 = 63;
  localparam int M1 = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din8 = '0;
  logic [5:0] sel0 = '0;
  logic [3:0] sel1 = '0;
  logic [0:0] dout0;
  logic [7:0] dout1;

  always #5 clk = ~clk;

  prog_delay_line u0 (
    .clk(clk), .rst(rst), .din(din8[0:0]), .dly_sel(sel0), .dout(dout0)
  );

  prog_delay_line #(.WIDTH(8), .MAX_DELAY(M1)) u1 (
    .clk(clk), .rst(rst), .din(din8), .dly_sel(sel1), .dout(dout1)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] hist [0:4095];
  int n = 0;

  // Stimulus: din[17:10], sel for u0 [9:4], sel for u1 [3:0].
  localparam logic [17:0] VEC [0:19] = '{
    {8'hA5, 6'd0,  4'd0},  {8'h3C, 6'd1,  4'd1},  {8'h5A, 6'd1,  4'd2},
    {8'hFF, 6'd2,  4'd3},  {8'h01, 6'd3,  4'd1},  {8'h80, 6'd0,  4'd0},
    {8'h7E, 6'd4,  4'd4},  {8'h11, 6'd5,  4'd5},  {8'h22, 6'd2,  4'd6},
    {8'h33, 6'd6,  4'd7},  {8'hC3, 6'd7,  4'd8},  {8'h96, 6'd8,  4'd9},
    {8'h69, 6'd1,  4'd10}, {8'h0F, 6'd9,  4'd3},  {8'hF0, 6'd10, 4'd2},
    {8'hAA, 6'd11, 4'd11}, {8'h55, 6'd12, 4'd1},  {8'hE7, 6'd3,  4'd0},
    {8'h18, 6'd13, 4'd5},  {8'hBD, 6'd14, 4'd4}
  };

  function automatic logic [7:0] model(input int k, input int maxd,
                                       input logic [7:0] cur);
    int kk;
    int idx;
    kk = (k > maxd) ? maxd : k;
    if (kk == 0) return cur;
    idx = n - kk + 1;
    if (idx < 1) return 8'h00;
    return hist[idx];
  endfunction

  task automatic chk(input string tag, input logic [7:0] got,
                     input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at cycle %0d", tag, got, exp, n);
    end
  endtask

  // Drive at the falling edge, check shortly after, then capture.
  task automatic step(input logic [7:0] d, input int s0, input int s1,
                      input string tag);
    @(negedge clk);
    din8 = d;
    sel0 = 6'(s0);
    sel1 = 4'(s1);
    #1;
    chk({tag, " u0"}, {7'b0, dout0}, {7'b0, model(s0, M0, d) & 8'h01});
    chk({tag, " u1"}, dout1, model(s1, M1, d));
    @(posedge clk);
    n++;
    hist[n] = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R1: reset state, long delays show zeros before history exists.
    for (int i = 0; i < 5; i++) step(8'hFF, 63, 10, "R1 reset state");

    // Table walk: R3 delays, R6 full word width.
    for (int i = 0; i < 20; i++)
      step(VEC[i][17:10], int'(VEC[i][9:4]), int'(VEC[i][3:0]), "R3/R6 table");

    // R2: zero select passes the word with no delay.
    for (int i = 0; i < 6; i++) step(8'(i * 37 + 9), 0, 0, "R2 pass");

    // R4: select changes mid-stream use stored history at once.
    for (int i = 0; i < 8; i++) step(8'(i * 19 + 3), 3, 3, "R4 before");
    step(8'h44, 7, 8, "R4 switch up");
    step(8'h45, 2, 1, "R4 switch down");
    step(8'h46, 0, 0, "R4 switch zero");
    step(8'h47, 5, 6, "R4 switch back");

    // R5: deepest delay with an alternating pattern.
    for (int i = 0; i < 70; i++) step(8'(i % 3 == 0 ? 8'hFF : 8'h00), 63, 10, "R5 max");
    for (int i = 0; i < 10; i++) step(8'(i), 62 - i, 9 - i, "R5 sweep");

    // R7: out-of-range select on the 10-deep instance.
    for (int i = 0; i < 4; i++) step(8'(8'hD0 + i), 1, 11 + i, "R7 clamp");

    // R1: reset in mid-run clears stored data.
    for (int i = 0; i < 12; i++) step(8'hFF, 1, 1, "R1 fill");
    do_reset();
    for (int i = 0; i < 4; i++) step(8'h81, 63, 10, "R1 after reset");
    step(8'h81, 1, 1, "R1 first word");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule